// File: doc/BRIEF.md
# Fixed-Point RGB to YCbCr Colour Converter

This block turns one 8-bit-per-channel RGB pixel into its luma (Y) and two chroma (Cb, Cr) samples. A pixel is accepted on any clock where the input strobe is high. The result appears exactly three clocks later with its own strobe. Pixels leave in the order they arrived, and a new pixel can be accepted on every clock.

Each of the nine products uses a constant coefficient magnitude. The magnitude is the real coefficient scaled by 2^FRAC_W and rounded to the nearest integer. Where a term is subtractive, the product itself is negated, rather than multiplying by a negative constant.

The three pipeline stages are:
- Stage 1 forms the nine products.
- Stage 2 adds the three signed terms of each output.
- Stage 3 adds the chroma mid-level of 128 (zero for luma) and half an output LSB, drops the fractional bits, and clamps the result to 0..255.

Every stage register is loaded only when the stage before it holds valid data, so the outputs hold their last value between pixels.

Top module: `ycc_conv`

## Requirements
- R1: `out_y` is within one count of clamp(round(0.299·R + 0.587·G + 0.114·B)) for every input pixel.
- R2: `out_cb` is within one count of clamp(round(128 − 0.1687·R − 0.3313·G + 0.5·B)) for every input pixel.
- R3: `out_cr` is within one count of clamp(round(128 + 0.5·R − 0.4187·G − 0.0813·B)) for every input pixel.
- R4: A neutral grey pixel (R = G = B = v) at the default FRAC_W of 14 gives `out_y` = v and `out_cb` = `out_cr` = 128 exactly.
- R5: Black (0,0,0) gives Y = 0, Cb = 128, Cr = 128. White (255,255,255) gives Y = 255, Cb = 128, Cr = 128.
- R6: An out-of-range result saturates:
  - Pure red (255,0,0) gives Cr = 255, not 256.
  - Pure blue (0,0,255) gives Cb = 255.
- R7: `out_valid` is `in_valid` delayed by exactly three clocks, and the results come out in input order, one per accepted pixel.
- R8: While `in_valid` is low, the input channels have no effect. Three clocks later `out_valid` is low, and `out_y`, `out_cb` and `out_cr` keep their previous values.
- R9: Driving `rst_n` low asynchronously clears `out_valid` and all three samples to 0. Pixels that were in flight at reset never produce an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The input pixel is valid this clock |
| in_r | input | PIX_W | Red channel |
| in_g | input | PIX_W | Green channel |
| in_b | input | PIX_W | Blue channel |
| out_valid | output | 1 | The output samples hold a new result |
| out_y | output | PIX_W | Luma sample |
| out_cb | output | PIX_W | Blue-difference chroma sample |
| out_cr | output | PIX_W | Red-difference chroma sample |

## Verification
The bench uses several kinds of input, each aimed at a different fault:
- **Coarse grid.** A grid over the RGB cube with a step of 17 per channel, plus a pseudo-random stream, is compared against a rounded real-number model. This exposes any wrong coefficient, wrong sign or wrong offset.
- **Grey diagonal.** The full grey ramp is compared exactly. Because the quantised luma weights sum to one and the chroma weights sum to zero, an off-by-one in rounding shows up here even though the tolerant grid check would miss it.
- **Saturated primaries.** Pure red and pure blue drive the chroma clamp at its top.
- **Single isolated pixels.** These expose the pipeline depth and the hold behaviour.
- **Reset mid-flight.** A reset asserted while a pixel is in flight shows that no stale result escapes.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  // Coefficient magnitudes in units of 1e-4, rows Y/Cb/Cr, columns R/G/B.
  function automatic int coef_milli(input int row, input int col);
    case (row * 3 + col)
      0: return 2990;
      1: return 5870;
      2: return 1140;
      3: return 1687;
      4: return 3313;
      5: return 5000;
      6: return 5000;
      7: return 4187;
      default: return 813;
    endcase
  endfunction

  // Subtractive terms: Cb from R and G, Cr from G and B.
  function automatic bit coef_neg(input int row, input int col);
    return (row == 1 && col < 2) || (row == 2 && col > 0);
  endfunction

  // Fixed-point magnitude rounded to nearest: round(c * 2^frac).
  function automatic int coef_mag(input int row, input int col, input int frac);
    longint scaled;
    scaled = longint'(coef_milli(row, col)) * (longint'(1) << frac);
    return int'((scaled + 64'sd5000) / 64'sd10000);
  endfunction

endpackage

// File: rtl/ycc_term_mul.sv
module ycc_term_mul #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 14,
  parameter int MAG    = 4899,
  parameter bit NEG    = 1'b0,
  localparam int TERM_W = PIX_W + FRAC_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [PIX_W-1:0]         pix,
  output logic signed [TERM_W-1:0] term
);

  localparam logic [TERM_W-1:0] MAG_V = TERM_W'(MAG);

  logic [TERM_W-1:0]        prod;
  logic signed [TERM_W-1:0] term_d;

  always_comb begin
    prod = TERM_W'(pix) * MAG_V;
    // Subtractive term: negate the product itself.
    if (NEG) term_d = signed'(-prod);
    else     term_d = signed'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  term <= '0;
    else if (en) term <= term_d;
  end

endmodule

// File: rtl/ycc_row_sum.sv
module ycc_row_sum #(
  parameter int TERM_W = 24,
  localparam int SUM_W = TERM_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [TERM_W-1:0] t0,
  input  logic signed [TERM_W-1:0] t1,
  input  logic signed [TERM_W-1:0] t2,
  output logic signed [SUM_W-1:0]  sum
);

  logic signed [SUM_W-1:0] sum_d;

  always_comb begin
    sum_d = SUM_W'(t0) + SUM_W'(t1) + SUM_W'(t2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sum <= '0;
    else if (en) sum <= sum_d;
  end

endmodule

// File: rtl/ycc_round_sat.sv
module ycc_round_sat #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 14,
  parameter int SUM_W  = 26,
  parameter int OFFSET = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [SUM_W-1:0] sum,
  output logic [PIX_W-1:0]        pix
);

  localparam int BIAS_W = SUM_W + 1;
  // Mid-level offset and half an output LSB, both in fixed-point units.
  localparam logic signed [BIAS_W-1:0] BIAS_V =
    BIAS_W'((longint'(OFFSET) << FRAC_W) + (longint'(1) << (FRAC_W - 1)));

  logic signed [BIAS_W-1:0] biased;
  logic signed [BIAS_W-1:0] whole;
  logic [PIX_W-1:0]         pix_d;

  always_comb begin
    biased = BIAS_W'(sum) + BIAS_V;
    whole  = biased >>> FRAC_W;
    if (whole[BIAS_W-1])
      pix_d = '0;
    else if (whole[BIAS_W-2:PIX_W] != '0)
      pix_d = '1;
    else
      pix_d = whole[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pix <= '0;
    else if (en) pix <= pix_d;
  end

endmodule

// File: rtl/ycc_conv.sv
module ycc_conv #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_cb,
  output logic [PIX_W-1:0] out_cr
);

  import ycc_pkg::*;

  localparam int TERM_W = PIX_W + FRAC_W + 2;
  localparam int SUM_W  = TERM_W + 2;
  localparam int N_OUT  = 3;
  localparam int N_IN   = 3;
  localparam int MID    = 1 << (PIX_W - 1);

  logic [PIX_W-1:0]        chan  [N_IN];
  logic signed [TERM_W-1:0] terms [N_OUT][N_IN];
  logic signed [SUM_W-1:0]  sums  [N_OUT];
  logic [PIX_W-1:0]        res   [N_OUT];

  logic v1_q, v2_q, v3_q;
  logic v1_d, v2_d, v3_d;

  assign chan[0] = in_r;
  assign chan[1] = in_g;
  assign chan[2] = in_b;

  // Valid pipeline: next-state and register kept apart.
  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
    v3_d = v2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      v3_q <= v3_d;
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_row
    for (genvar c = 0; c < N_IN; c++) begin : g_col
      ycc_term_mul #(
        .PIX_W (PIX_W),
        .FRAC_W(FRAC_W),
        .MAG   (coef_mag(o, c, FRAC_W)),
        .NEG   (coef_neg(o, c))
      ) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (in_valid),
        .pix  (chan[c]),
        .term (terms[o][c])
      );
    end

    ycc_row_sum #(.TERM_W(TERM_W)) u_sum (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (v1_q),
      .t0   (terms[o][0]),
      .t1   (terms[o][1]),
      .t2   (terms[o][2]),
      .sum  (sums[o])
    );

    ycc_round_sat #(
      .PIX_W (PIX_W),
      .FRAC_W(FRAC_W),
      .SUM_W (SUM_W),
      .OFFSET((o == 0) ? 0 : MID)
    ) u_rnd (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (v2_q),
      .sum  (sums[o]),
      .pix  (res[o])
    );
  end

  assign out_valid = v3_q;
  assign out_y     = res[0];
  assign out_cb    = res[1];
  assign out_cr    = res[2];

endmodule

// File: rtl/ycc_conv_chk.sv
module ycc_conv_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_r,
  input logic [PIX_W-1:0] in_g,
  input logic [PIX_W-1:0] in_b,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_y,
  input logic [PIX_W-1:0] out_cb,
  input logic [PIX_W-1:0] out_cr
);

  localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W - 1));

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= 2'd0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd3) && !$past(in_valid, 3)) |->
      ($stable(out_y) && $stable(out_cb) && $stable(out_cr)));

  assert_black_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd3) && $past(in_valid && in_r == '0 && in_g == '0 && in_b == '0, 3)) |->
      (out_y == '0 && out_cb == MID && out_cr == MID));

  assert_grey_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd3) && $past(in_valid && in_r == in_g && in_g == in_b, 3)) |->
      (out_cb >= MID - 1'b1 && out_cb <= MID + 1'b1 &&
       out_cr >= MID - 1'b1 && out_cr <= MID + 1'b1));

endmodule

bind ycc_conv ycc_conv_chk #(.PIX_W(PIX_W)) u_ycc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_r     (in_r),
  .in_g     (in_g),
  .in_b     (in_b),
  .out_valid(out_valid),
  .out_y    (out_y),
  .out_cb   (out_cb),
  .out_cr   (out_cr)
);

// File: tb/ycc_conv_bench.sv
`timescale 1ns/1ps
module ycc_conv_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic       out_valid;
  logic [7:0] out_y, out_cb, out_cr;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  mon_en = 1'b0;
  bit  done = 1'b0;
  logic [23:0] exp_q[$];
  logic [23:0] px;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  ycc_conv u_ycc_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int ch, input int r, input int g, input int b);
    real v;
    int  k;
    case (ch)
      0:       v = 0.299 * r + 0.587 * g + 0.114 * b;
      1:       v = 128.0 - 0.1687 * r - 0.3313 * g + 0.5 * b;
      default: v = 128.0 + 0.5 * r - 0.4187 * g - 0.0813 * b;
    endcase
    k = $rtoi(v + 0.5);
    if (k < 0) k = 0;
    if (k > 255) k = 255;
    return k;
  endfunction

  function automatic bit near(input int a, input int e);
    return (a - e <= 1) && (e - a <= 1);
  endfunction

  // Scoreboard: every output must match the oldest pixel sent.
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 output with no pixel pending", 1, 0);
      end else begin
        px = exp_q.pop_front();
        chk(near(int'(out_y), model(0, px[23:16], px[15:8], px[7:0])),
            "R1 luma", out_y, model(0, px[23:16], px[15:8], px[7:0]));
        chk(near(int'(out_cb), model(1, px[23:16], px[15:8], px[7:0])),
            "R2 Cb", out_cb, model(1, px[23:16], px[15:8], px[7:0]));
        chk(near(int'(out_cr), model(2, px[23:16], px[15:8], px[7:0])),
            "R3 Cr", out_cr, model(2, px[23:16], px[15:8], px[7:0]));
        if (px[23:16] == px[15:8] && px[15:8] == px[7:0]) begin
          chk(out_y == px[23:16], "R4 grey luma", out_y, px[23:16]);
          chk(out_cb == 8'd128 && out_cr == 8'd128, "R4 grey chroma",
              {out_cb, out_cr}, {8'd128, 8'd128});
        end
      end
    end
  end

  task automatic send(input int r, input int g, input int b);
    @(negedge clk);
    in_valid = 1'b1;
    in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    exp_q.push_back({8'(r), 8'(g), 8'(b)});
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    in_r = lfsr[7:0]; in_g = lfsr[15:8]; in_b = lfsr[11:4];
  endtask

  // One isolated pixel: checks the three-clock latency, returns the samples.
  task automatic probe(input int r, input int g, input int b,
                       output int y, output int cb, output int cr);
    @(negedge clk);
    in_valid = 1'b1;
    in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid, "R7 valid after one clock", out_valid, 0);
    @(negedge clk);
    chk(!out_valid, "R7 valid after two clocks", out_valid, 0);
    @(negedge clk);
    chk(out_valid, "R7 valid after three clocks", out_valid, 1);
    y = out_y; cb = out_cb; cr = out_cr;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    int y, cb, cr;
    repeat (3) @(negedge clk);
    chk(!out_valid && out_y == 0 && out_cb == 0 && out_cr == 0,
        "R9 outputs in reset", {out_valid, out_y, out_cb, out_cr}, 0);
    rst_n = 1'b1;

    probe(0, 0, 0, y, cb, cr);
    chk(y == 0 && cb == 128 && cr == 128, "R5 black", (y << 16) | (cb << 8) | cr,
        (0 << 16) | (128 << 8) | 128);
    probe(255, 255, 255, y, cb, cr);
    chk(y == 255 && cb == 128 && cr == 128, "R5 white", (y << 16) | (cb << 8) | cr,
        (255 << 16) | (128 << 8) | 128);
    probe(255, 0, 0, y, cb, cr);
    chk(cr == 255, "R6 red saturates Cr", cr, 255);
    chk(near(y, 76) && near(cb, 85), "R1 R2 pure red", (y << 8) | cb, (76 << 8) | 85);
    probe(0, 0, 255, y, cb, cr);
    chk(cb == 255, "R6 blue saturates Cb", cb, 255);

    // Invalid cycles with changing data must leave the outputs untouched.
    probe(10, 200, 90, y, cb, cr);
    for (int i = 0; i < 6; i++) begin
      idle();
      chk(!out_valid, "R8 no valid on idle", out_valid, 0);
      chk(out_y == 8'(y) && out_cb == 8'(cb) && out_cr == 8'(cr), "R8 outputs hold",
          {out_y, out_cb, out_cr}, {8'(y), 8'(cb), 8'(cr)});
    end

    // Reset with a pixel in flight: nothing may come out afterwards.
    @(negedge clk);
    in_valid = 1'b1; in_r = 8'd50; in_g = 8'd60; in_b = 8'd70;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!out_valid && out_y == 0 && out_cb == 0 && out_cr == 0,
        "R9 async clear", {out_valid, out_y, out_cb, out_cr}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid, "R9 no stale output", out_valid, 0);
    end

    // Scoreboarded sweeps.
    mon_en = 1'b1;
    for (int r = 0; r < 256; r += 17)
      for (int g = 0; g < 256; g += 17)
        for (int b = 0; b < 256; b += 17) begin
          send(r, g, b);
          if (((r + g + b) % 7) == 3) idle();
        end
    for (int v = 0; v < 256; v++) send(v, v, v);
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr[7:0], lfsr[15:8], lfsr[11:4] ^ lfsr[3:0]);
      if (lfsr[2:0] == 3'd5) idle();
    end
    idle();
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R7 every pixel produced one output", exp_q.size(), 0);

    done = 1'b1;
    summary();
  end

endmodule